// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the word address for one port of a synchronous RAM. On every rising clock edge it decides, from three active-low controls, which address the RAM uses in that cycle: address zero, an address taken from the external bus, the address used in the previous cycle, or that previous address plus one. The chosen address appears combinationally on `use_addr` in the same cycle. It is also captured in a register so that the next cycle can hold it or step from it.

A host uses the load control to start a burst at any address. It then lets the counter step through consecutive words, and it can pause the burst by holding. The clear control restarts at address zero with no lost cycle. A read or write at address zero can take place in the same cycle as the clear. Chip enables and byte selects never reach this block, so clearing, loading and stepping happen whether or not the RAM access itself is enabled.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, `held_addr` becomes 0. After reset is released, `held_addr` reads 0 until the first active edge updates it.
- R2: When `clr_n` is low, `use_addr` is 0 whatever `strobe_n`, `adv_n` and `ext_addr` are.
- R3: When `clr_n` is high and `strobe_n` is low, `use_addr` equals `ext_addr` in that same cycle.
- R4: When `clr_n`, `strobe_n` and `adv_n` are all high, `use_addr` equals `held_addr`, and `ext_addr` has no effect on it.
- R5: When `clr_n` and `strobe_n` are high and `adv_n` is low, `use_addr` equals `held_addr` plus one in that same cycle.
- R6: Stepping from the all-ones address (0xFFFF at the default width) gives address 0.
- R7: After each rising edge with `rst_n` high, `held_addr` equals the `use_addr` of the cycle before that edge.
- R8: Priority is clear over load over step. With `strobe_n` and `adv_n` both low and `clr_n` high, the external address is loaded and is not incremented.
- R9: A clear costs no dead cycle. A step in the cycle right after a clear uses address 1, and a hold in that cycle uses address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the held address |
| ext_addr | input | ADDR_W | Address presented on the external bus |
| strobe_n | input | 1 | Active-low load of `ext_addr` |
| adv_n | input | 1 | Active-low step of the address by one |
| clr_n | input | 1 | Active-low clear of the address to zero |
| use_addr | output | ADDR_W | Address the RAM uses in the current cycle |
| held_addr | output | ADDR_W | Registered address from the previous cycle |

## Verification
A wrong held address shows up on `held_addr` at the next sample after the edge that captured it. It also shows up on `use_addr` in the first hold or step cycle that reads it, so at most one cycle goes by before a mismatch can be seen. A fault in the priority decode or the incrementer shows up on `use_addr` in the same cycle as the faulty control pattern. For that reason the bench walks every combination of the three controls from several starting addresses. It also drives the all-ones step and the sequences right after a clear.

// File: rtl/burst_addr_pkg.sv
// Shared types for the burst address generator.
// Assumes: one operation is chosen per clock cycle.
package burst_addr_pkg;
    typedef enum logic [1:0] {
        OP_CLEAR   = 2'd0,
        OP_LOAD    = 2'd1,
        OP_ADVANCE = 2'd2,
        OP_HOLD    = 2'd3
    } addr_op_e;
endpackage

// File: rtl/burst_op_decode.sv
// Priority decoder: turns the three active-low controls into one operation.
// Assumes: clear outranks load, and load outranks step.
module burst_op_decode
    import burst_addr_pkg::*;
(
    input  logic     clr_n,
    input  logic     strobe_n,
    input  logic     adv_n,
    output addr_op_e op
);
    // Select the highest-priority active control.
    always_comb begin
        if (!clr_n)         op = OP_CLEAR;
        else if (!strobe_n) op = OP_LOAD;
        else if (!adv_n)    op = OP_ADVANCE;
        else                op = OP_HOLD;
    end
endmodule

// File: rtl/burst_addr_step.sv
// Modular incrementer: adds one to an address and wraps at 2**ADDR_W.
// Assumes: the carry out of the top bit is thrown away.
module burst_addr_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] cur,
    output logic [ADDR_W-1:0] nxt
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    // Increment, with the wrap happening through truncation.
    always_comb nxt = cur + ONE;
endmodule

// File: rtl/burst_addr_reg.sv
// Holding register for the address used in the last cycle.
// Assumes: synchronous active-low reset to zero.
module burst_addr_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Capture the address used in this cycle for the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Per-port burst address generator.
// It chooses this cycle's RAM address from clear, load, step or hold and keeps a registered copy.
// Assumes: the controls are synchronous to clk; chip enables and byte selects are handled elsewhere.
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              adv_n,
    input  logic              clr_n,
    output logic [ADDR_W-1:0] use_addr,
    output logic [ADDR_W-1:0] held_addr
);
    addr_op_e          op;
    logic [ADDR_W-1:0] stepped;

    burst_op_decode u_dec (
        .clr_n    (clr_n),
        .strobe_n (strobe_n),
        .adv_n    (adv_n),
        .op       (op)
    );

    burst_addr_step #(.ADDR_W(ADDR_W)) u_step (
        .cur (held_addr),
        .nxt (stepped)
    );

    // Same-cycle address select driven by the decoded operation.
    always_comb begin
        unique case (op)
            OP_CLEAR:   use_addr = '0;
            OP_LOAD:    use_addr = ext_addr;
            OP_ADVANCE: use_addr = stepped;
            default:    use_addr = held_addr;
        endcase
    end

    burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (use_addr),
        .q     (held_addr)
    );
endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker for burst_addr_gen, attached to it through bind.
// Assumes: the ports of the generator are observed at each rising edge.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              adv_n,
    input logic              clr_n,
    input logic [ADDR_W-1:0] use_addr,
    input logic [ADDR_W-1:0] held_addr
);
    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> use_addr == '0);
    // R3
    load_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !strobe_n) |-> use_addr == ext_addr);
    // R4
    hold_prev_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && adv_n) |-> use_addr == held_addr);
    // R5
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && strobe_n && !adv_n) |-> use_addr == ADDR_W'(held_addr + ADDR_W'(1)));
    // R7
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> held_addr == $past(use_addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .adv_n     (adv_n),
    .clr_n     (clr_n),
    .use_addr  (use_addr),
    .held_addr (held_addr)
);

// File: tb/burst_addr_gen_test.sv
`timescale 1ns/1ps
module burst_addr_gen_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ext_addr = '0;
    logic         strobe_n = 1'b1;
    logic         adv_n = 1'b1;
    logic         clr_n = 1'b1;
    logic [W-1:0] use_addr;
    logic [W-1:0] held_addr;

    int unsigned  checks = 0;
    int unsigned  errors = 0;
    logic [W-1:0] model_held = '0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .adv_n(adv_n), .clr_n(clr_n), .use_addr(use_addr), .held_addr(held_addr)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: check the held copy, drive the controls, check the address used, then clock.
    task automatic step(input logic c, input logic s, input logic a,
                        input logic [W-1:0] ext, input string req);
        logic [W-1:0] exp;
        check("R7", held_addr, model_held);
        clr_n = c; strobe_n = s; adv_n = a; ext_addr = ext;
        #1;
        if (!c)      exp = '0;
        else if (!s) exp = ext;
        else if (!a) exp = model_held + 1'b1;
        else         exp = model_held;
        check(req, use_addr, exp);
        @(posedge clk);
        model_held = exp;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] seeds [4];
        seeds[0] = 16'h0000; seeds[1] = 16'h1234; seeds[2] = 16'h7FFF; seeds[3] = 16'hFFFE;
        // R1: reset state, with a load applied during reset
        strobe_n = 1'b0; ext_addr = 16'hBEEF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", held_addr, '0);
        rst_n = 1'b1; strobe_n = 1'b1;
        #1 check("R1", held_addr, '0);

        // Sweep all control combinations from several loaded starting points
        foreach (seeds[i]) begin
            for (int k = 0; k < 8; k++) begin
                step(1'b1, 1'b0, 1'b1, seeds[i], "R3");
                step(k[2], k[1], k[0], ~seeds[i],
                     !k[2] ? "R2" : !k[1] ? "R8" : !k[0] ? "R5" : "R4");
            end
        end

        // R6: wrap from all ones
        step(1'b1, 1'b0, 1'b1, 16'hFFFF, "R3");
        step(1'b1, 1'b1, 1'b0, 16'h5555, "R6");
        check("R6", held_addr, 16'h0000);

        // R9: no dead cycle after a clear
        step(1'b1, 1'b0, 1'b1, 16'h4321, "R3");
        step(1'b0, 1'b0, 1'b0, 16'h9999, "R2");
        step(1'b1, 1'b1, 1'b1, 16'hAAAA, "R9");
        step(1'b1, 1'b1, 1'b0, 16'hAAAA, "R9");
        check("R9", held_addr, 16'h0001);

        // R4: a burst paused by holding ignores the external bus
        for (int n = 0; n < 6; n++) step(1'b1, 1'b1, 1'b1, W'($urandom), "R4");

        // Random mixes, biased so that steps and holds dominate
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 15);
            step(r != 0, r > 2, r > 8, W'($urandom), "R5");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule